// File: doc/BRIEF.md
# Integer ALU with Immediate Formation

This block is the 32-bit integer execution unit of a load-store processor. Each cycle it takes two register operands, a 16-bit immediate field, a 5-bit operation code and a select bit. The select bit says whether the second operand is the register value or the immediate. It returns one 32-bit result in the same cycle, with no internal state. The supported operations are bitwise logic, wrapping addition and subtraction, register or immediate moves, ten relational tests that produce 0 or 1, shifts and rotates.

The block does not use a single immediate form. The 16-bit field is zero-extended, sign-extended or moved into the upper half, and the choice depends on the operation class. An operand-former stage makes that choice before any arithmetic, so the functional units see only 32-bit operands. Codes outside the table, and two immediate forms that are not defined, return zero and raise a flag the pipeline can turn into an exception.

Top module: `int_alu`

## Requirements
- R1: Operation codes: 0 and, 1 or, 2 xor, 3 nor, 4 add, 5 sub, 6 and-high, 7 or-high, 8 xor-high, 9 move-high, 10 move-unsigned, 11 move, 12 eq, 13 ne, 14 ge signed, 15 ge unsigned, 16 gt signed, 17 gt unsigned, 18 le signed, 19 le unsigned, 20 lt signed, 21 lt unsigned, 22 shift left logical, 23 shift right logical, 24 shift right arithmetic, 25 rotate left, 26 rotate right. Codes 27 to 31, and codes 3 or 26 with `use_imm_i`=1, are illegal. An illegal operation drives `result_o` to 0 and `illegal_o` to 1.
- R2: Codes 0 to 3 combine `a_i` with `b_i` bitwise when `use_imm_i`=0. With `use_imm_i`=1, codes 0 to 2 use the immediate zero-extended to 32 bits.
- R3: Codes 6 to 8 apply and, or and xor to `a_i` and the immediate placed in bits 31..16 with zeros in bits 15..0, whatever the value of `use_imm_i`.
- R4: Add and sub wrap modulo 2^32. With `use_imm_i`=1 the second operand is the sign-extended immediate.
- R5: Move returns `b_i` when `use_imm_i`=0, and the sign-extended immediate when `use_imm_i`=1. Move-high returns the immediate in bits 31..16 with zeros below. Move-unsigned returns the zero-extended immediate. Both of the last two ignore `use_imm_i` and `a_i`.
- R6: Every comparison returns exactly 0 or 1 in bit 0, with bits 31..1 at zero. Eq and ne compare against `b_i`, or against the sign-extended immediate when `use_imm_i`=1.
- R7: The signed relations treat both operands as two's complement. Their immediate form is sign-extended.
- R8: The unsigned relations treat both operands as unsigned. Their immediate form is zero-extended.
- R9: Shifts move `a_i` by the low 5 bits of `b_i`, or of the immediate when `use_imm_i`=1. Logical shifts fill with zeros and the arithmetic right shift replicates bit 31. A zero amount returns `a_i` unchanged.
- R10: Rotate left accepts a register or immediate amount (low 5 bits). Rotate right accepts only a register amount.
- R11: `illegal_o` is 0 for every legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | 1 selects the formed immediate as second operand |
| op_i | input | 5 | Operation code |
| result_o | output | 32 | Result |
| illegal_o | output | 1 | Operation code or form not defined |

## Verification
The block is purely combinational, so any fault shows on `result_o` or `illegal_o` for the same input vector. Nothing is held over to a later cycle. A wrong immediate form shows up only for immediates with bit 15 set, or for operations that look at the upper half. For that reason the stimulus forces both immediate polarities for every class. A wrong borrow or sign decision in the comparator shows up only when the operands straddle the sign boundary or are equal, so those pairs are driven on purpose.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int XLEN  = 32;
  localparam int IMMW  = 16;
  localparam int SHW   = $clog2(XLEN);
  localparam int OPW   = 5;

  typedef enum logic [OPW-1:0] {
    OP_AND    = 5'd0,  OP_OR     = 5'd1,  OP_XOR    = 5'd2,  OP_NOR    = 5'd3,
    OP_ADD    = 5'd4,  OP_SUB    = 5'd5,  OP_ANDHI  = 5'd6,  OP_ORHI   = 5'd7,
    OP_XORHI  = 5'd8,  OP_MOVHI  = 5'd9,  OP_MOVUI  = 5'd10, OP_MOV    = 5'd11,
    OP_EQ     = 5'd12, OP_NE     = 5'd13, OP_GE     = 5'd14, OP_GEU    = 5'd15,
    OP_GT     = 5'd16, OP_GTU    = 5'd17, OP_LE     = 5'd18, OP_LEU    = 5'd19,
    OP_LT     = 5'd20, OP_LTU    = 5'd21, OP_SLL    = 5'd22, OP_SRL    = 5'd23,
    OP_SRA    = 5'd24, OP_ROL    = 5'd25, OP_ROR    = 5'd26
  } alu_op_e;

  localparam logic [OPW-1:0] OP_LAST = 5'd26;

  typedef enum logic [1:0] {
    IMM_NONE, IMM_ZEXT, IMM_SEXT, IMM_HIGH
  } imm_mode_e;

  function automatic logic [XLEN-1:0] imm_zext(input logic [IMMW-1:0] v);
    return {{(XLEN-IMMW){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] imm_sext(input logic [IMMW-1:0] v);
    return {{(XLEN-IMMW){v[IMMW-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] imm_high(input logic [IMMW-1:0] v);
    return {v, {(XLEN-IMMW){1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] rot_left(input logic [XLEN-1:0] v,
                                               input logic [SHW-1:0] n);
    logic [2*XLEN-1:0] t;
    t = {v, v} << n;
    return t[2*XLEN-1:XLEN];
  endfunction

  function automatic logic [XLEN-1:0] rot_right(input logic [XLEN-1:0] v,
                                                input logic [SHW-1:0] n);
    logic [2*XLEN-1:0] t;
    t = {v, v} >> n;
    return t[XLEN-1:0];
  endfunction
endpackage

// File: rtl/alu_operand_former.sv
module alu_operand_former
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] reg_b,
  input  logic [IMMW-1:0] imm,
  input  logic            use_imm,
  input  alu_op_e         op,
  output logic [XLEN-1:0] opnd_b,
  output imm_mode_e       mode
);
  always_comb begin
    mode = IMM_NONE;
    case (op)
      OP_AND, OP_OR, OP_XOR:                 mode = use_imm ? IMM_ZEXT : IMM_NONE;
      OP_ADD, OP_SUB, OP_MOV:                mode = use_imm ? IMM_SEXT : IMM_NONE;
      OP_EQ, OP_NE, OP_GE, OP_GT, OP_LE, OP_LT:
                                             mode = use_imm ? IMM_SEXT : IMM_NONE;
      OP_GEU, OP_GTU, OP_LEU, OP_LTU:        mode = use_imm ? IMM_ZEXT : IMM_NONE;
      OP_SLL, OP_SRL, OP_SRA, OP_ROL:        mode = use_imm ? IMM_ZEXT : IMM_NONE;
      OP_ANDHI, OP_ORHI, OP_XORHI, OP_MOVHI: mode = IMM_HIGH;
      OP_MOVUI:                              mode = IMM_ZEXT;
      default:                               mode = IMM_NONE;
    endcase
  end

  always_comb begin
    case (mode)
      IMM_ZEXT: opnd_b = imm_zext(imm);
      IMM_SEXT: opnd_b = imm_sext(imm);
      IMM_HIGH: opnd_b = imm_high(imm);
      default:  opnd_b = reg_b;
    endcase
  end

  always_comb begin
    if (!$isunknown({imm, mode})) begin
      // R2
      zext_upper_zero_chk: assert (mode != IMM_ZEXT || opnd_b[XLEN-1:IMMW] == '0);
      // R3
      high_lower_zero_chk: assert (mode != IMM_HIGH ||
                                   (opnd_b[IMMW-1:0] == '0 && opnd_b[XLEN-1:XLEN-IMMW] == imm));
      // R4
      sext_upper_copy_chk: assert (mode != IMM_SEXT ||
                                   opnd_b[XLEN-1:IMMW] == {(XLEN-IMMW){imm[IMMW-1]}});
    end
  end
endmodule

// File: rtl/alu_logic_arith.sv
module alu_logic_arith
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] sum_w;
  logic [XLEN-1:0] dif_w;

  assign sum_w = opnd_a + opnd_b;
  assign dif_w = opnd_a + ~opnd_b + 1'b1;

  always_comb begin
    case (op)
      OP_AND, OP_ANDHI:            res = opnd_a & opnd_b;
      OP_OR,  OP_ORHI:             res = opnd_a | opnd_b;
      OP_XOR, OP_XORHI:            res = opnd_a ^ opnd_b;
      OP_NOR:                      res = ~(opnd_a | opnd_b);
      OP_ADD:                      res = sum_w;
      OP_SUB:                      res = dif_w;
      OP_MOV, OP_MOVHI, OP_MOVUI:  res = opnd_b;
      default:                     res = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b})) begin
      // R4
      add_sub_inverse_chk: assert (dif_w + opnd_b == opnd_a);
    end
  end
endmodule

// File: rtl/alu_compare.sv
module alu_compare
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  alu_op_e         op,
  output logic            hit
);
  logic [XLEN:0] diff_w;
  logic          eq_w;
  logic          ltu_w;
  logic          lts_w;

  assign diff_w = {1'b0, opnd_a} - {1'b0, opnd_b};
  assign eq_w   = (diff_w[XLEN-1:0] == '0);
  assign ltu_w  = diff_w[XLEN];
  assign lts_w  = (opnd_a[XLEN-1] ^ opnd_b[XLEN-1]) ? opnd_a[XLEN-1] : diff_w[XLEN-1];

  always_comb begin
    case (op)
      OP_EQ:   hit = eq_w;
      OP_NE:   hit = !eq_w;
      OP_GE:   hit = !lts_w;
      OP_GEU:  hit = !ltu_w;
      OP_GT:   hit = !lts_w && !eq_w;
      OP_GTU:  hit = !ltu_w && !eq_w;
      OP_LE:   hit = lts_w || eq_w;
      OP_LEU:  hit = ltu_w || eq_w;
      OP_LT:   hit = lts_w;
      OP_LTU:  hit = ltu_w;
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b})) begin
      // R8
      unsigned_borrow_chk: assert (ltu_w == (opnd_a < opnd_b));
      // R7
      signed_less_chk: assert (lts_w == ($signed(opnd_a) < $signed(opnd_b)));
      // R6
      equal_exclusive_chk: assert (!(eq_w && (ltu_w || lts_w)));
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] val,
  input  logic [SHW-1:0]  amt,
  input  alu_op_e         op,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] sll_w, srl_w, sra_w, rol_w, ror_w;

  assign sll_w = val << amt;
  assign srl_w = val >> amt;
  assign sra_w = $unsigned($signed(val) >>> amt);
  assign rol_w = rot_left(val, amt);
  assign ror_w = rot_right(val, amt);

  always_comb begin
    case (op)
      OP_SLL:  res = sll_w;
      OP_SRL:  res = srl_w;
      OP_SRA:  res = sra_w;
      OP_ROL:  res = rol_w;
      OP_ROR:  res = ror_w;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({val, amt})) begin
      // R10
      rotate_mirror_chk: assert (ror_w == rot_left(val, SHW'(0) - amt));
      // R9
      zero_amount_identity_chk: assert (amt != '0 ||
                                        (sll_w == val && srl_w == val && sra_w == val));
      // R9
      sra_sign_fill_chk: assert (amt == '0 || sra_w[XLEN-1] == val[XLEN-1]);
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            use_imm_i,
  input  logic [OPW-1:0]  op_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  alu_op_e         op_w;
  imm_mode_e       mode_w;
  logic [XLEN-1:0] opnd_b_w;
  logic [XLEN-1:0] la_res_w;
  logic [XLEN-1:0] sh_res_w;
  logic            cmp_hit_w;
  logic            is_cmp_w;
  logic            is_shift_w;
  logic            bad_code_w;
  logic            bad_form_w;

  assign op_w = alu_op_e'(op_i);

  alu_operand_former u_former (
    .reg_b   (b_i),
    .imm     (imm_i),
    .use_imm (use_imm_i),
    .op      (op_w),
    .opnd_b  (opnd_b_w),
    .mode    (mode_w)
  );

  alu_logic_arith u_la (
    .opnd_a (a_i),
    .opnd_b (opnd_b_w),
    .op     (op_w),
    .res    (la_res_w)
  );

  alu_compare u_cmp (
    .opnd_a (a_i),
    .opnd_b (opnd_b_w),
    .op     (op_w),
    .hit    (cmp_hit_w)
  );

  alu_shifter u_sh (
    .val (a_i),
    .amt (opnd_b_w[SHW-1:0]),
    .op  (op_w),
    .res (sh_res_w)
  );

  assign bad_code_w = (op_i > OP_LAST);
  assign bad_form_w = use_imm_i && (op_w == OP_NOR || op_w == OP_ROR);
  assign illegal_o  = bad_code_w || bad_form_w;
  assign is_cmp_w   = (op_i >= OP_EQ)  && (op_i <= OP_LTU);
  assign is_shift_w = (op_i >= OP_SLL) && (op_i <= OP_ROR);

  always_comb begin
    if (illegal_o)       result_o = '0;
    else if (is_cmp_w)   result_o = {{(XLEN-1){1'b0}}, cmp_hit_w};
    else if (is_shift_w) result_o = sh_res_w;
    else                 result_o = la_res_w;
  end

  always_comb begin
    if (!$isunknown({op_i, use_imm_i, a_i, b_i, imm_i})) begin
      // R1
      illegal_zero_result_chk: assert (!illegal_o || result_o == '0);
      // R6
      compare_boolean_chk: assert (!is_cmp_w || result_o[XLEN-1:1] == '0);
      // R5
      movhi_form_chk: assert (op_w != OP_MOVHI || result_o == {imm_i, 16'h0000});
      // R11
      legal_code_flag_chk: assert (op_i > OP_LAST || (op_w != OP_NOR && op_w != OP_ROR) ||
                                   illegal_o == use_imm_i);
    end
  end
endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb_top;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic        ui;
  logic [4:0]  op;
  logic [31:0] res;
  logic        ill;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  int_alu dut_i (
    .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(ui), .op_i(op),
    .result_o(res), .illegal_o(ill)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      $display("FAIL watchdog: run did not complete");
      errors = errors + 1;
      checks = checks + 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic string req_of(input logic [4:0] o, input logic u);
    if (o > 26 || (u && (o == 3 || o == 26))) return "R1";
    if (o <= 3)  return "R2";
    if (o <= 5)  return "R4";
    if (o <= 8)  return "R3";
    if (o <= 11) return "R5";
    if (o <= 13) return "R6";
    if (o == 14 || o == 16 || o == 18 || o == 20) return "R7";
    if (o <= 21) return "R8";
    if (o <= 24) return "R9";
    return "R10";
  endfunction

  // expected {illegal, result}
  function automatic logic [32:0] model(input logic [4:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [15:0] k,
                                        input logic u);
    logic [31:0] ks, kz, kh, yo, ys;
    logic [4:0]  n;
    logic [31:0] r;
    ks = {{16{k[15]}}, k};
    kz = {16'h0, k};
    kh = {k, 16'h0};
    ys = u ? ks : y;
    yo = u ? kz : y;
    n  = u ? k[4:0] : y[4:0];
    r  = 32'h0;
    if (o > 26 || (u && (o == 3 || o == 26))) return {1'b1, 32'h0};
    case (o)
      0:  r = x & yo;
      1:  r = x | yo;
      2:  r = x ^ yo;
      3:  r = ~(x | y);
      4:  r = x + ys;
      5:  r = x - ys;
      6:  r = x & kh;
      7:  r = x | kh;
      8:  r = x ^ kh;
      9:  r = kh;
      10: r = kz;
      11: r = ys;
      12: r = 32'(x == ys);
      13: r = 32'(x != ys);
      14: r = 32'($signed(x) >= $signed(ys));
      15: r = 32'(x >= yo);
      16: r = 32'($signed(x) >  $signed(ys));
      17: r = 32'(x >  yo);
      18: r = 32'($signed(x) <= $signed(ys));
      19: r = 32'(x <= yo);
      20: r = 32'($signed(x) <  $signed(ys));
      21: r = 32'(x <  yo);
      22: r = x << n;
      23: r = x >> n;
      24: begin
        r = x;
        for (int i = 0; i < 32; i++) if (i < n) r = {x[31], r[31:1]};
      end
      25: begin
        r = x;
        for (int i = 0; i < 32; i++) if (i < n) r = {r[30:0], r[31]};
      end
      26: begin
        r = x;
        for (int i = 0; i < 32; i++) if (i < n) r = {r[0], r[31:1]};
      end
      default: r = 32'h0;
    endcase
    return {1'b0, r};
  endfunction

  task automatic run(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic [15:0] k, input logic u, input string tag);
    logic [32:0] exp;
    @(negedge clk);
    op = o; a = x; b = y; imm = k; ui = u;
    #2;
    exp = model(o, x, y, k, u);
    checks = checks + 1;
    if ({ill, res} !== exp) begin
      errors = errors + 1;
      $display("FAIL %s op=%0d ui=%0b a=%h b=%h imm=%h: got ill=%0b res=%h exp ill=%0b res=%h",
               tag, o, u, x, y, k, ill, res, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    int unsigned s;
    op = 5'd0; a = '0; b = '0; imm = '0; ui = 1'b0;
    s = $urandom(32'd1234);
    repeat (2) @(negedge clk);
    // initial quiescent state
    run(5'd0, 32'h0, 32'h0, 16'h0, 1'b0, "R11");
    // R1 illegal codes and forms
    run(5'd27, 32'hFFFF_FFFF, 32'h1, 16'h1, 1'b0, "R1");
    run(5'd31, 32'h1234_5678, 32'h1, 16'hFFFF, 1'b1, "R1");
    run(5'd3, 32'h0, 32'h0, 16'h0, 1'b1, "R1");
    run(5'd26, 32'h8000_0001, 32'h1, 16'h1, 1'b1, "R1");
    // R2 logical, zero-extended immediate
    run(5'd0, 32'hFFFF_FFFF, 32'h0, 16'hF00F, 1'b1, "R2");
    run(5'd3, 32'h0F0F_0000, 32'h0000_00F0, 16'h0, 1'b0, "R2");
    // R3 high variants ignore use_imm
    run(5'd7, 32'h0000_1234, 32'hFFFF_FFFF, 16'hABCD, 1'b0, "R3");
    run(5'd8, 32'hFFFF_FFFF, 32'h0, 16'h8001, 1'b1, "R3");
    // R4 wrap and sign-extension
    run(5'd4, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, "R4");
    run(5'd4, 32'h0000_0005, 32'h0, 16'hFFFF, 1'b1, "R4");
    run(5'd5, 32'h0, 32'h1, 16'h0, 1'b0, "R4");
    run(5'd5, 32'h0, 32'h0, 16'h8000, 1'b1, "R4");
    // R5 moves
    run(5'd11, 32'h0, 32'hDEAD_BEEF, 16'h7FFF, 1'b0, "R5");
    run(5'd11, 32'h0, 32'h0, 16'h8000, 1'b1, "R5");
    run(5'd9, 32'hFFFF_FFFF, 32'h5, 16'h8765, 1'b0, "R5");
    run(5'd10, 32'hFFFF_FFFF, 32'h5, 16'h8765, 1'b1, "R5");
    // R6 equality
    run(5'd12, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1'b1, "R6");
    run(5'd13, 32'h7, 32'h7, 16'h0, 1'b0, "R6");
    // R7 signed around sign boundary
    run(5'd20, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, "R7");
    run(5'd16, 32'h0, 32'h0, 16'hFFFF, 1'b1, "R7");
    run(5'd18, 32'h5, 32'h5, 16'h0, 1'b0, "R7");
    // R8 unsigned, zero-extended immediate
    run(5'd21, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, "R8");
    run(5'd21, 32'h0000_FFFE, 32'h0, 16'hFFFF, 1'b1, "R8");
    run(5'd15, 32'h5, 32'h5, 16'h0, 1'b0, "R8");
    // R9 shifts
    run(5'd24, 32'h8000_0000, 32'h1F, 16'h0, 1'b0, "R9");
    run(5'd23, 32'h8000_0000, 32'hFFFF_FFE4, 16'h0, 1'b0, "R9");
    run(5'd22, 32'h1234_5678, 32'h0, 16'h0, 1'b0, "R9");
    run(5'd24, 32'h8765_4321, 32'h0, 16'hFF20, 1'b1, "R9");
    // R10 rotates
    run(5'd25, 32'h8000_0001, 32'h0, 16'h0001, 1'b1, "R10");
    run(5'd26, 32'h8000_0001, 32'h21, 16'h0, 1'b0, "R10");
    run(5'd25, 32'hA5A5_0F0F, 32'h1F, 16'h0, 1'b0, "R10");
    // random mix, both immediate polarities
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  ro;
      logic [31:0] ra, rb;
      logic [15:0] rk;
      logic        ru;
      ro = 5'($urandom);
      ra = $urandom;
      rb = $urandom;
      rk = 16'($urandom);
      ru = 1'($urandom);
      if (i % 4 == 0) ra = {ra[31], 31'h0};
      if (i % 5 == 0) rb = ra;
      run(ro, ra, rb, rk, ru, req_of(ro, ru));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule